// File: doc/BRIEF.md
# Stepped Clock Gear Controller

This block softens the load step a chip sees when its master clock moves between a slow setting and full PLL speed. It does not make a new clock. It drives a clock-enable that passes a chosen share of the PLL clock cycles, and it moves that share through a series of stages. Software sets four things: a starting step, a step increment, a dwell count (how many pattern periods each stage lasts) and an enable. Software then pulses a start request. The block reports one of four two-bit states: resting low, rising, resting high and falling. The start bit reads back as 1 while a ramp is in progress, and the hardware clears it when the ramp finishes.

The gating pattern is spread evenly. It comes from an accumulator: at step n the accumulator adds n+1 each cycle, and a carry out of a 128-wide range opens one cycle. Step changes happen only at the boundary of a 128-cycle period. Accepting a start request restarts the period, so every stage lasts whole periods. There is no data stream here, so there is no valid/ready handshake. All configuration, request and status pins are plain levels that are sampled on every rising clock edge.

Top module: `gear_ramp_ctrl`

## Requirements
- R1: While cfg_en is 0, clk_en is held at 1, gear_status reads 00, start_bit reads 0 and start_wr pulses have no effect.
- R2: While enabled and resting low (status 00), any 128 consecutive cycles contain exactly cfg_start_step+1 cycles with clk_en at 1.
- R3: A start_wr pulse accepted in status 00 moves the status to 01 at that edge, and start_bit reads 1 from then on.
- R4: cfg_step_sel values 0, 1, 2 and 3 select a stage increment of 1, 2, 4 and 8. Rising saturates at step 127, and falling stops at cfg_start_step.
- R5: Each stage lasts (cfg_dwell+1) whole 128-cycle periods, counted from the accepting edge. A ramp from step s with increment i therefore ends exactly 128*(cfg_dwell+1)*k cycles after that edge, where k = ceil((127-s)/i), and k = 1 when s = 127.
- R6: When the rise reaches step 127, the status becomes 10 and clk_en stays at 1 on every cycle.
- R7: A start_wr pulse accepted in status 10 moves the status to 11. After the time given in R5 the status becomes 00, and the rate returns to that of R2.
- R8: Hardware clears start_bit on the edge where a ramp ends. start_wr pulses during status 01 or 11 are ignored and do not restart or lengthen the ramp.
- R9: Clearing cfg_en during a ramp ends the ramp: on the next edge the status reads 00 and start_bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PLL-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Gear enable |
| cfg_start_step | input | 7 | Starting (lowest) step, 0..127 |
| cfg_step_sel | input | 2 | Stage increment select: 1, 2, 4 or 8 |
| cfg_dwell | input | 8 | Pattern periods per stage, minus one |
| start_wr | input | 1 | One-cycle write of 1 to the start bit |
| start_bit | output | 1 | Start bit readback; 1 while a ramp is in progress |
| gear_status | output | 2 | 00 low, 01 rising, 10 high, 11 falling |
| clk_en | output | 1 | Cycle-gating enable for the master clock |

## Verification
The hardest case to reach is the exact edge on which a ramp ends. That edge depends on the dwell count, the increment and the saturation clamp all together, and a start request pulsed in the middle of the ramp must not move it. A table of configurations covers each increment. The table also includes start steps where the last stage is clamped and one where the start step is already 127. For each configuration the bench waits the computed number of cycles minus one, checks that the ramp is still in progress, and checks that it has ended one cycle later. It injects a stray start pulse halfway through every ramp.

// File: rtl/gear_pkg.sv
package gear_pkg;
  typedef enum logic [1:0] {
    GS_LOW  = 2'b00,
    GS_RISE = 2'b01,
    GS_HIGH = 2'b10,
    GS_FALL = 2'b11
  } gear_state_e;
endpackage

// File: rtl/gear_phase.sv
// Pattern period counter; restarts on an accepted start request.
module gear_phase #(
  parameter int STEP_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic period_end
);
  logic [STEP_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else              phase_q <= phase_q + 1'b1;
  end

  assign period_end = &phase_q;

  // R5: after a restart the period always begins at zero
  assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !period_end);
endmodule

// File: rtl/gear_pattern.sv
// Evenly spread gating: step n opens n+1 of every 2**STEP_W cycles.
module gear_pattern #(
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step,
  output logic              pass
);
  localparam logic [STEP_W-1:0] FULL = '1;

  logic [STEP_W-1:0] acc_q;
  logic [STEP_W:0]   sum;
  logic              pass_q;

  assign sum = {1'b0, acc_q} + {1'b0, step} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      acc_q  <= sum[STEP_W-1:0];
      pass_q <= sum[STEP_W];
    end
  end

  assign pass = pass_q;

  // R6: top step passes every cycle
  assert_full_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step == FULL) |=> pass);
endmodule

// File: rtl/gear_sequencer.sv
// Four-state ramp sequencer with dwell counting and saturation.
module gear_sequencer
  import gear_pkg::*;
#(
  parameter int STEP_W  = 7,
  parameter int SEL_W   = 2,
  parameter int DWELL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic [STEP_W-1:0]  cfg_start_step,
  input  logic [SEL_W-1:0]   cfg_step_sel,
  input  logic [DWELL_W-1:0] cfg_dwell,
  input  logic               start_wr,
  input  logic               period_end,
  output logic               restart,
  output logic [STEP_W-1:0]  step,
  output gear_state_e        state,
  output logic               start_bit
);
  localparam logic [STEP_W-1:0] FULL = '1;

  gear_state_e        state_q;
  logic [STEP_W-1:0]  step_q;
  logic [DWELL_W-1:0] dwell_q;
  logic               busy_q;

  logic [STEP_W:0]   inc_w;
  logic [STEP_W:0]   up_sum;
  logic [STEP_W:0]   floor_w;
  logic [STEP_W-1:0] up_next;
  logic [STEP_W-1:0] dn_next;
  logic              stage_done;
  logic              resting;

  assign inc_w   = (STEP_W+1)'(1) << cfg_step_sel;
  assign up_sum  = {1'b0, step_q} + inc_w;
  assign up_next = (up_sum > {1'b0, FULL}) ? FULL : up_sum[STEP_W-1:0];
  assign floor_w = {1'b0, cfg_start_step} + inc_w;
  assign dn_next = ({1'b0, step_q} <= floor_w) ? cfg_start_step
                                               : step_q - inc_w[STEP_W-1:0];

  assign stage_done = period_end && (dwell_q == cfg_dwell);
  assign resting    = (state_q == GS_LOW) || (state_q == GS_HIGH);
  assign restart    = cfg_en && start_wr && resting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_LOW;
      step_q  <= '0;
      dwell_q <= '0;
      busy_q  <= 1'b0;
    end else if (!cfg_en) begin
      state_q <= GS_LOW;
      step_q  <= cfg_start_step;
      dwell_q <= '0;
      busy_q  <= 1'b0;
    end else begin
      case (state_q)
        GS_LOW: begin
          step_q <= cfg_start_step;
          if (start_wr) begin
            state_q <= GS_RISE;
            busy_q  <= 1'b1;
            dwell_q <= '0;
          end
        end
        GS_RISE: begin
          if (stage_done) begin
            dwell_q <= '0;
            step_q  <= up_next;
            if (up_next == FULL) begin
              state_q <= GS_HIGH;
              busy_q  <= 1'b0;
            end
          end else if (period_end) begin
            dwell_q <= dwell_q + 1'b1;
          end
        end
        GS_HIGH: begin
          step_q <= FULL;
          if (start_wr) begin
            state_q <= GS_FALL;
            busy_q  <= 1'b1;
            dwell_q <= '0;
          end
        end
        default: begin
          if (stage_done) begin
            dwell_q <= '0;
            step_q  <= dn_next;
            if (dn_next == cfg_start_step) begin
              state_q <= GS_LOW;
              busy_q  <= 1'b0;
            end
          end else if (period_end) begin
            dwell_q <= dwell_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign step      = step_q;
  assign state     = state_q;
  assign start_bit = busy_q;

  // R3: accepted start at rest low begins the rise
  assert_low_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && start_wr && state_q == GS_LOW) |=> (state_q == GS_RISE && busy_q));
  // R7: accepted start at rest high begins the fall
  assert_high_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && start_wr && state_q == GS_HIGH) |=> (state_q == GS_FALL));
  // R8: start bit is set exactly while a ramp runs
  assert_busy_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q == (state_q == GS_RISE || state_q == GS_FALL));
  // R1/R9: disable forces rest low
  assert_disable_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (state_q == GS_LOW && !busy_q));
  // R4: the rise never skips past the top step back to a lower one
  assert_rise_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && state_q == GS_RISE && $past(cfg_en) && $past(state_q) == GS_RISE)
      |-> step_q >= $past(step_q));
endmodule

// File: rtl/gear_ramp_ctrl.sv
module gear_ramp_ctrl
  import gear_pkg::*;
#(
  parameter int STEP_W  = 7,
  parameter int SEL_W   = 2,
  parameter int DWELL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic [STEP_W-1:0]  cfg_start_step,
  input  logic [SEL_W-1:0]   cfg_step_sel,
  input  logic [DWELL_W-1:0] cfg_dwell,
  input  logic               start_wr,
  output logic               start_bit,
  output logic [1:0]         gear_status,
  output logic               clk_en
);
  logic              period_end;
  logic              restart;
  logic [STEP_W-1:0] step;
  gear_state_e       state;
  logic              pass;

  gear_phase #(.STEP_W(STEP_W)) phase_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .period_end(period_end)
  );

  gear_sequencer #(.STEP_W(STEP_W), .SEL_W(SEL_W), .DWELL_W(DWELL_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
    .cfg_start_step(cfg_start_step), .cfg_step_sel(cfg_step_sel),
    .cfg_dwell(cfg_dwell), .start_wr(start_wr), .period_end(period_end),
    .restart(restart), .step(step), .state(state), .start_bit(start_bit)
  );

  gear_pattern #(.STEP_W(STEP_W)) pat_i (
    .clk(clk), .rst_n(rst_n), .step(step), .pass(pass)
  );

  assign gear_status = state;
  assign clk_en      = !cfg_en || pass;

  // R1: no gating while disabled
  assert_disabled_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> clk_en);
  // R6: resting high one cycle later still gates nothing
  assert_high_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gear_status == 2'b10 && $past(gear_status) == 2'b10) |-> clk_en);
endmodule

// File: tb/gear_ramp_ctrl_tb_top.sv
`timescale 1ns/1ps
module gear_ramp_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic [6:0] cfg_start_step = '0;
  logic [1:0] cfg_step_sel = '0;
  logic [7:0] cfg_dwell = '0;
  logic       start_wr = 1'b0;
  logic       start_bit;
  logic [1:0] gear_status;
  logic       clk_en;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  gear_ramp_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
    .cfg_start_step(cfg_start_step), .cfg_step_sel(cfg_step_sel),
    .cfg_dwell(cfg_dwell), .start_wr(start_wr), .start_bit(start_bit),
    .gear_status(gear_status), .clk_en(clk_en)
  );

  // fields: start step [16:10], step select [9:8], dwell [7:0]
  localparam logic [16:0] VEC [0:5] = '{
    {7'd0,   2'd3, 8'd0},
    {7'd100, 2'd0, 8'd1},
    {7'd64,  2'd2, 8'd3},
    {7'd120, 2'd1, 8'd2},
    {7'd127, 2'd0, 8'd0},
    {7'd5,   2'd1, 8'd0}
  };

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_open(output int n);
    n = 0;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      if (clk_en) n++;
    end
  endtask

  function automatic int ramp_cycles(input int s, input int sel, input int dw);
    int inc = 1 << sel;
    int k = (s == 127) ? 1 : ((127 - s) + inc - 1) / inc;
    return 128 * (dw + 1) * k;
  endfunction

  // pulse start, check the ramp state, inject a stray start halfway,
  // and check the exact ending edge
  task automatic run_ramp(input int t, input int ramp_code, input int end_code,
                          input string req);
    @(negedge clk) start_wr = 1'b1;
    @(posedge clk);
    @(negedge clk) start_wr = 1'b0;
    check({req, " ramp status"}, gear_status, ramp_code);
    check("R3 start bit set", start_bit, 1);
    repeat (t/2 - 1) @(posedge clk);
    @(negedge clk) start_wr = 1'b1;
    @(posedge clk);
    @(negedge clk) start_wr = 1'b0;
    repeat (t - 1 - t/2) @(posedge clk);
    @(negedge clk);
    check("R5 R8 still ramping one cycle early", gear_status, ramp_code);
    @(posedge clk);
    @(negedge clk);
    check({req, " R5 end status on exact edge"}, gear_status, end_code);
    check("R8 start bit cleared", start_bit, 0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 reset status", gear_status, 0);
    check("R1 reset start bit", start_bit, 0);
    check("R1 reset clk_en", clk_en, 1);
    rst_n = 1'b1;

    // R1: disabled block ignores start and never gates
    @(negedge clk) start_wr = 1'b1;
    @(negedge clk) start_wr = 1'b0;
    check("R1 disabled status", gear_status, 0);
    check("R1 disabled start bit", start_bit, 0);
    count_open(n);
    check("R1 disabled open count", n, 128);

    cfg_en = 1'b1;
    for (int v = 0; v < 6; v++) begin
      int s  = VEC[v][16:10];
      int sl = VEC[v][9:8];
      int dw = VEC[v][7:0];
      int t;
      cfg_start_step = 7'(s);
      cfg_step_sel   = 2'(sl);
      cfg_dwell      = 8'(dw);
      t = ramp_cycles(s, sl, dw);
      repeat (4) @(negedge clk);
      count_open(n);
      check("R2 low rate", n, s + 1);
      run_ramp(t, 1, 2, "R4 R6 rise");
      repeat (2) @(negedge clk);
      count_open(n);
      check("R6 full rate", n, 128);
      run_ramp(t, 3, 0, "R4 R7 fall");
      repeat (4) @(negedge clk);
      count_open(n);
      check("R7 rate after fall", n, s + 1);
    end

    // R9: disabling during a rise abandons it
    cfg_start_step = 7'd10; cfg_step_sel = 2'd0; cfg_dwell = 8'd0;
    repeat (4) @(negedge clk);
    start_wr = 1'b1;
    @(negedge clk) start_wr = 1'b0;
    repeat (300) @(negedge clk);
    check("R9 rising before disable", gear_status, 1);
    cfg_en = 1'b0;
    @(negedge clk);
    check("R9 status after disable", gear_status, 0);
    check("R9 start bit after disable", start_bit, 0);
    cfg_en = 1'b1;
    repeat (4) @(negedge clk);
    count_open(n);
    check("R9 R2 rate after re-enable", n, 11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule